// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects fifteen interrupt request sources, folds them onto nine vectors and hands the CPU one vector address at a time. Four of the sources are external pins with their own trigger detection. The other eleven are one-cycle request pulses from on-chip peripherals. Each vector has a one-bit priority select. The first two vectors choose between high and highest. The other seven choose between low and high. A handler running at one level can be preempted only by a request at a strictly higher level, so up to three handlers can be nested.

The CPU side is a valid/ready stream. The block raises `irq_valid` with a vector address and a level. Once raised, the offer keeps the same address and level until the CPU accepts it with `irq_ready`, even if a more urgent request arrives in the meantime. The offer is a commitment, so back-pressure from the CPU only delays it. When the offer is accepted, its level is marked in service. A one-cycle `reti` pulse at the end of a handler clears the highest level in service.

Edge-detected requests and peripheral requests are latched. They stay set until software clears them through `src_clr`, even after the CPU has taken their vector. Level-triggered pin requests are never latched: they follow the pin.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset there is no offer (`irq_valid` low), no level is in service and every latched request flag is clear.
- R2: Source index s maps onto vectors as follows:
  - s0 to s3 (ext_pin bits 0 to 3) go to vectors 0 to 3 in order.
  - `periph_req` bit p is source s = 4 + p. Bit 0 goes to vector 2, bit 1 to vector 3 and bit 2 to vector 4. Bits 3 and 4 go to vector 5, bit 5 to vector 6, bits 6 to 8 to vector 7, and bits 9 and 10 to vector 8.
  - The address offered for vector v is 0x03 + 8*v.
- R3: Pins 0 and 1 each take a 2-bit mode: pin 0 uses `ext01_mode[1:0]` and pin 1 uses `ext01_mode[3:2]`. Mode 00 triggers on a rising edge, 01 on a falling edge, 10 while the pin is high and 11 while the pin is low. A level-mode request is not latched and disappears when the pin leaves the active level.
- R4: Pins 2 and 3 each take a 2-bit mode: pin 2 uses `ext23_mode[1:0]` and pin 3 uses `ext23_mode[3:2]`. Mode 00 triggers on a rising edge, 01 on a falling edge, and 10 or 11 on both edges.
- R5: An edge event or a peripheral pulse sets a latched flag. The flag stays set across masking, acceptance and `reti` until its `src_clr` bit is driven high. If a set and a clear happen in the same cycle, the set wins.
- R6: The `vec_hi` bit for vector 0 or 1 selects high (0) or highest (1). For vectors 2 to 8 it selects low (0) or high (1). The offered level is encoded 0 = low, 1 = high, 2 = highest.
- R7: Among eligible vectors, the one with the highest level is offered. Among vectors at that level, the lowest vector number is offered.
- R8: A vector is offered only when its level is strictly above every level in service. An accepted offer marks its level in service.
- R9: A `reti` pulse clears the highest level in service. It has no effect when no level is in service.
- R10: A vector is eligible only while its `vec_en` bit and `global_en` are both high.
- R11: While `irq_valid` is high and `irq_ready` is low, `irq_valid`, `irq_addr` and `irq_level` hold steady. In the cycle after an accept, `irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 4 | External interrupt pins, already synchronized |
| ext01_mode | input | 4 | Trigger modes for pins 0 and 1 (2 bits each) |
| ext23_mode | input | 4 | Trigger modes for pins 2 and 3 (2 bits each) |
| periph_req | input | 11 | One-cycle peripheral request pulses |
| src_clr | input | 15 | Per-source flag clear, indexed by source number |
| global_en | input | 1 | Master interrupt enable |
| vec_en | input | 9 | Per-vector enable |
| vec_hi | input | 9 | Per-vector priority select |
| irq_valid | output | 1 | Vector offer is valid |
| irq_ready | input | 1 | CPU accepts the offer |
| irq_addr | output | 8 | Vector address of the offer |
| irq_level | output | 2 | Priority level of the offer |
| reti | input | 1 | Return-from-interrupt pulse |

## Verification
Single sources are sent through each vector to confirm the source map and the addresses. The pin trigger modes are tried one by one, including a wrong-direction edge that must stay silent and a level request that must vanish once the pin moves. Pairs of requests raised in the same cycle separate two cases: a higher level beats a lower one, and the lower vector number wins between equal levels. A three-deep nest followed by returns one at a time shows that each `reti` strips only the top level. Finally, a higher request arriving while an offer is stalled shows that the stalled offer is not replaced.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int N_EXT  = 4;
  localparam int N_PER  = 11;
  localparam int N_SRC  = N_EXT + N_PER;
  localparam int N_VEC  = 9;
  localparam int N_TOP  = 2;               // vectors that may use the highest level
  localparam int N_LVL  = 3;
  localparam int VEC_W  = $clog2(N_VEC);

  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_LOW  = 2'd0;
  localparam lvl_t LVL_HIGH = 2'd1;
  localparam lvl_t LVL_TOP  = 2'd2;

  // source number -> vector number
  function automatic int src_vector(input int s);
    case (s)
      0, 1, 2, 3: return s;
      4:          return 2;
      5:          return 3;
      6:          return 4;
      7, 8:       return 5;
      9:          return 6;
      10, 11, 12: return 7;
      default:    return 8;
    endcase
  endfunction
endpackage

// File: rtl/irqc_pin_detect.sv
module irqc_pin_detect #(
  parameter bit LEVEL_OK = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] mode,
  output logic       evt,
  output logic       lvl_act,
  output logic       lvl_req
);
  logic prev, armed, rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev  <= 1'b0;
      armed <= 1'b0;
    end else begin
      prev  <= pin;
      armed <= 1'b1;
    end
  end

  assign rise = armed & pin & ~prev;
  assign fall = armed & ~pin & prev;

  if (LEVEL_OK) begin : g_level
    // 00 rise, 01 fall, 10 high level, 11 low level
    assign lvl_act = mode[1];
    assign lvl_req = mode[0] ? ~pin : pin;
    assign evt     = mode[1] ? 1'b0 : (mode[0] ? fall : rise);
  end else begin : g_edge
    // 00 rise, 01 fall, 1x both edges
    assign lvl_act = 1'b0;
    assign lvl_req = 1'b0;
    assign evt     = mode[1] ? (rise | fall) : (mode[0] ? fall : rise);
  end
endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank
  import irqc_pkg::*;
#(
  parameter int NS = N_SRC,
  parameter int NV = N_VEC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] set_i,
  input  logic [NS-1:0] clr_i,
  input  logic [NS-1:0] lvl_act,
  input  logic [NS-1:0] lvl_req,
  output logic [NV-1:0] req_vec
);
  logic [NS-1:0] flags;
  logic [NS-1:0] req_src;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_i) | set_i;
  end

  assign req_src = (lvl_act & lvl_req) | (~lvl_act & flags);

  for (genvar v = 0; v < NV; v++) begin : g_vec
    logic [NS-1:0] sel;
    for (genvar s = 0; s < NS; s++) begin : g_src
      assign sel[s] = (src_vector(s) == v) ? req_src[s] : 1'b0;
    end
    assign req_vec[v] = |sel;
  end

  // R5: a set flag survives every cycle without its clear
  p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~clr_i) != '0) |=> ((($past(flags) & ~$past(clr_i)) & ~flags) == '0))
    else $error("flag dropped without clear");
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int NV = N_VEC,
  parameter int NT = N_TOP,
  parameter int NL = N_LVL,
  localparam int VW = $clog2(NV)
) (
  input  logic [NV-1:0] pend,
  input  logic [NV-1:0] vec_hi,
  input  logic [NL-1:0] in_svc,
  output logic          win_valid,
  output logic [VW-1:0] win_vec,
  output lvl_t          win_lvl
);
  lvl_t          vlvl [NV];
  logic [NV-1:0] elig;

  for (genvar v = 0; v < NV; v++) begin : g_lvl
    if (v < NT) begin : g_top
      assign vlvl[v] = vec_hi[v] ? LVL_TOP : LVL_HIGH;
    end else begin : g_norm
      assign vlvl[v] = vec_hi[v] ? LVL_HIGH : LVL_LOW;
    end
    assign elig[v] = pend[v] && ((in_svc >> vlvl[v]) == '0);
  end

  always_comb begin
    win_valid = 1'b0;
    win_vec   = '0;
    win_lvl   = LVL_LOW;
    for (int v = NV - 1; v >= 0; v--) begin
      if (elig[v] && (!win_valid || vlvl[v] >= win_lvl)) begin
        win_valid = 1'b1;
        win_vec   = VW'(v);
        win_lvl   = vlvl[v];
      end
    end
  end
endmodule

// File: rtl/irqc_nest_stack.sv
module irqc_nest_stack
  import irqc_pkg::*;
#(
  parameter int NL = N_LVL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  lvl_t          push_lvl,
  input  logic          pop,
  output logic [NL-1:0] in_svc
);
  logic [NL-1:0] top_bit;
  logic [NL-1:0] nxt;

  always_comb begin
    top_bit = '0;
    for (int l = 0; l < NL; l++) begin
      if (in_svc[l]) top_bit = NL'(1) << l;
    end
    nxt = in_svc & ~(pop ? top_bit : '0);
    if (push) nxt = nxt | (NL'(1) << push_lvl);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) in_svc <= '0;
    else        in_svc <= nxt;
  end

  // R8: an accepted level was not already in service
  p_push_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !in_svc[push_lvl])
    else $error("pushed level already in service");

  // R9: a return alone removes exactly one level
  p_pop_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && in_svc != '0) |=>
      ($countones(in_svc) + 1 == $countones($past(in_svc))))
    else $error("return did not clear exactly one level");
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_EXT-1:0]     ext_pin,
  input  logic [N_EXT-1:0]     ext01_mode,
  input  logic [N_EXT-1:0]     ext23_mode,
  input  logic [N_PER-1:0]     periph_req,
  input  logic [N_SRC-1:0]     src_clr,
  input  logic                 global_en,
  input  logic [N_VEC-1:0]     vec_en,
  input  logic [N_VEC-1:0]     vec_hi,
  output logic                 irq_valid,
  input  logic                 irq_ready,
  output logic [ADDR_W-1:0]    irq_addr,
  output logic [1:0]           irq_level,
  input  logic                 reti
);
  localparam int HALF = N_EXT / 2;

  logic [N_EXT-1:0] ext_evt, ext_lvl_act, ext_lvl_req;
  logic [N_VEC-1:0] req_vec, pend;
  logic [N_LVL-1:0] in_svc;
  logic             win_valid;
  logic [VEC_W-1:0] win_vec;
  lvl_t             win_lvl;
  logic             off_valid;
  logic [VEC_W-1:0] off_vec;
  lvl_t             off_lvl;
  logic             accept;

  for (genvar i = 0; i < N_EXT; i++) begin : g_pin
    logic [1:0] mode_i;
    if (i < HALF) begin : g_lv
      assign mode_i = ext01_mode[2*i +: 2];
    end else begin : g_ed
      assign mode_i = ext23_mode[2*(i-HALF) +: 2];
    end
    irqc_pin_detect #(.LEVEL_OK(i < HALF)) u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (ext_pin[i]),
      .mode    (mode_i),
      .evt     (ext_evt[i]),
      .lvl_act (ext_lvl_act[i]),
      .lvl_req (ext_lvl_req[i])
    );
  end

  irqc_flag_bank #(.NS(N_SRC), .NV(N_VEC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   ({periph_req, ext_evt}),
    .clr_i   (src_clr),
    .lvl_act ({{N_PER{1'b0}}, ext_lvl_act}),
    .lvl_req ({{N_PER{1'b0}}, ext_lvl_req}),
    .req_vec (req_vec)
  );

  assign pend = req_vec & vec_en & {N_VEC{global_en}};

  irqc_arbiter #(.NV(N_VEC), .NT(N_TOP), .NL(N_LVL)) u_arb (
    .pend      (pend),
    .vec_hi    (vec_hi),
    .in_svc    (in_svc),
    .win_valid (win_valid),
    .win_vec   (win_vec),
    .win_lvl   (win_lvl)
  );

  assign accept = off_valid & irq_ready;

  irqc_nest_stack #(.NL(N_LVL)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accept),
    .push_lvl (off_lvl),
    .pop      (reti),
    .in_svc   (in_svc)
  );

  // offer register: loads only when empty, holds until accepted
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_valid <= 1'b0;
      off_vec   <= '0;
      off_lvl   <= LVL_LOW;
    end else if (off_valid) begin
      if (irq_ready) off_valid <= 1'b0;
    end else if (win_valid) begin
      off_valid <= 1'b1;
      off_vec   <= win_vec;
      off_lvl   <= win_lvl;
    end
  end

  assign irq_valid = off_valid;
  assign irq_level = off_lvl;
  assign irq_addr  = ADDR_W'(VEC_BASE) + ADDR_W'(off_vec) * ADDR_W'(VEC_STEP);

  // R11: a stalled offer holds steady
  p_offer_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=>
      (irq_valid && $stable(irq_addr) && $stable(irq_level)))
    else $error("offer changed while stalled");

  // R8: the offer is above every level in service
  p_offer_above_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((in_svc >> irq_level) == '0))
    else $error("offer not above levels in service");

  // R10: a new offer needs the master enable
  p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(global_en))
    else $error("offer raised while globally masked");
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ext_pin = '0;
  logic [3:0]  ext01_mode = '0;
  logic [3:0]  ext23_mode = '0;
  logic [10:0] periph_req = '0;
  logic [14:0] src_clr = '0;
  logic        global_en = 1'b1;
  logic [8:0]  vec_en = '1;
  logic [8:0]  vec_hi = '0;
  logic        irq_valid;
  logic        irq_ready = 1'b0;
  logic [7:0]  irq_addr;
  logic [1:0]  irq_level;
  logic        reti = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext01_mode(ext01_mode),
    .ext23_mode(ext23_mode), .periph_req(periph_req), .src_clr(src_clr),
    .global_en(global_en), .vec_en(vec_en), .vec_hi(vec_hi),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_addr(irq_addr),
    .irq_level(irq_level), .reti(reti)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: compares every handshake with the scoreboard
  always @(negedge clk) begin
    if (rst_n && irq_valid && irq_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected offer actual=0x%0h expected=none", irq_addr);
      end else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({irq_addr, irq_level} == e, t, {irq_addr, irq_level}, e);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic set_pin(input int p, input bit v);
    step(); ext_pin[p] = v;
  endtask

  task automatic pulse(input logic [10:0] m);
    step(); periph_req = m;
    step(); periph_req = '0;
  endtask

  task automatic clr(input int s);
    step(); src_clr[s] = 1'b1;
    step(); src_clr[s] = 1'b0;
  endtask

  task automatic ret();
    step(); reti = 1'b1;
    step(); reti = 1'b0;
  endtask

  task automatic idle(input int n, input string req);
    repeat (n) @(negedge clk);
    check(!irq_valid, req, irq_valid, 0);
  endtask

  task automatic take(input logic [7:0] a, input logic [1:0] l, input string req);
    bit seen = 0;
    for (int k = 0; k < 10 && !seen; k++) begin
      @(negedge clk);
      if (irq_valid) seen = 1;
    end
    if (!seen) begin
      check(0, req, 0, a);
    end else begin
      exp_q.push_back({a, l});
      tag_q.push_back(req);
      step(); irq_ready = 1'b1;
      step(); irq_ready = 1'b0;
      @(negedge clk);
      check(!irq_valid, "R11 drop after accept", irq_valid, 0);
    end
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) step();
    rst_n = 1'b1;
    @(negedge clk);
    check(!irq_valid, "R1 reset", irq_valid, 0);
    idle(4, "R1 no flags");

    // R2 / R3 rising edge on pin 0
    set_pin(0, 1);
    take(8'h03, 2'd1, "R2 pin0 vector");
    clr(0); ret();
    idle(4, "R9 empty after return");

    // R2 peripheral map
    pulse(11'h040); take(8'h3B, 2'd0, "R2 vsync vector7"); clr(10); ret();
    pulse(11'h200); take(8'h43, 2'd0, "R2 bus vector8");   clr(13); ret();
    pulse(11'h002); take(8'h1B, 2'd0, "R2 base vector3");  clr(5);  ret();

    // R6 / R7 level beats number
    vec_hi[8] = 1'b1;
    pulse(11'h420);
    take(8'h43, 2'd1, "R6 vector8 raised to high");
    idle(4, "R8 low blocked under high");
    clr(14); ret();
    take(8'h33, 2'd0, "R7 remaining low");
    clr(9); ret();
    vec_hi[8] = 1'b0;

    // R7 tie at same level
    pulse(11'h024);
    take(8'h23, 2'd0, "R7 lowest vector wins");
    clr(6);
    idle(4, "R8 equal level blocked");
    ret();
    take(8'h33, 2'd0, "R7 second of tie");
    clr(9); ret();

    // R8 three-deep nest
    pulse(11'h100);
    take(8'h3B, 2'd0, "R8 low handler");
    clr(12);
    vec_hi[4] = 1'b1;
    pulse(11'h004);
    take(8'h23, 2'd1, "R8 high preempts low");
    clr(6);
    vec_hi[0] = 1'b1;
    set_pin(0, 0); set_pin(0, 1);
    take(8'h03, 2'd2, "R8 highest preempts high");
    clr(0);
    vec_hi[5] = 1'b1;
    pulse(11'h008);
    idle(4, "R8 high blocked at depth 3");
    ret();
    idle(4, "R9 high still in service");
    ret();
    take(8'h2B, 2'd1, "R9 high freed");
    clr(7); ret(); ret();
    idle(4, "R9 stack empty");
    vec_hi = '0;

    // R3 level modes on pin 1 (pin 1 low)
    step(); ext01_mode[3:2] = 2'b11;
    take(8'h0B, 2'd1, "R3 low level");
    set_pin(1, 1); ret();
    idle(4, "R3 level not latched");
    step(); ext01_mode[3:2] = 2'b10;
    take(8'h0B, 2'd1, "R3 high level");
    step(); ext01_mode[3:2] = 2'b00;
    ret();
    idle(4, "R3 level gone with mode");
    // R3 falling edge on pin 0 (pin 0 high)
    step(); ext01_mode[1:0] = 2'b01;
    set_pin(0, 0);
    take(8'h03, 2'd1, "R3 falling edge");
    clr(0); ret();

    // R4 both edges on pin 2, falling on pin 3
    step(); ext23_mode = 4'b0110;
    set_pin(2, 1);
    take(8'h13, 2'd0, "R4 both rise");
    clr(2); ret();
    set_pin(2, 0);
    take(8'h13, 2'd0, "R4 both fall");
    clr(2); ret();
    set_pin(3, 1);
    idle(4, "R4 rise ignored in fall mode");
    set_pin(3, 0);
    take(8'h1B, 2'd0, "R4 falling pin3");
    clr(3); ret();

    // R10 / R5 masking and latching
    step(); global_en = 1'b0;
    pulse(11'h001);
    idle(6, "R10 global mask");
    step(); global_en = 1'b1;
    take(8'h13, 2'd0, "R5 latched across mask");
    ret();
    take(8'h13, 2'd0, "R5 still latched after return");
    clr(4); ret();
    idle(4, "R5 cleared");
    step(); vec_en[6] = 1'b0;
    pulse(11'h020);
    idle(4, "R10 vector mask");
    step(); vec_en[6] = 1'b1;
    take(8'h33, 2'd0, "R10 unmasked");
    clr(9); ret();

    // R11 stalled offer is not replaced
    pulse(11'h040);
    repeat (4) @(negedge clk);
    set_pin(1, 0); set_pin(1, 1);
    repeat (4) @(negedge clk);
    check(irq_valid && irq_addr == 8'h3B, "R11 offer held", irq_addr, 8'h3B);
    take(8'h3B, 2'd0, "R11 held offer taken");
    take(8'h0B, 2'd1, "R11 then preemption");
    clr(1); clr(10); ret(); ret();
    idle(4, "R9 final empty");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule